// File: doc/BRIEF.md
# Capture Length Controller

This block keeps the two length settings of a logic-analyzer acquisition, the number of samples to hand back and the number of samples to take after the trigger. It also runs one acquisition against them. The host sends commands as an 8-bit opcode with a 32-bit data word, qualified by `cmd_valid`. One opcode loads both lengths at once from two packed 16-bit fields, for hosts that only know the short format. Two other opcodes load each length as a full 32-bit sample count. Both paths write the same two stored values, so the write that lands last decides the value.

The acquisition side watches the sample stream that feeds the capture memory through its valid/ready pair. A sample counts only in a cycle where `smp_valid` and `smp_ready` are both high; the block never stalls the stream, and a sample that is offered but not taken is not counted. An arm pulse opens capture and freezes the lengths for that run. After the trigger the block counts the post-trigger delay, then closes capture and pulses `done`. `read_len` reports how many samples are held for readback. A reset opcode aborts a run without losing the settings.

Top module: `capture_len_ctrl`

## Requirements
- R1: After `rst_n` is released, `capture_en`, `done` and `read_len` are 0, and both configured counts read 4, the value a packed write of zero fields would give.
- R2: Opcode 0x81 takes the read field from data bits 15:0 and the delay field from bits 31:16, and with `mux_mode` low it stores each as (field+1)*4 samples, so the largest value is 262144.
- R3: With `mux_mode` high, opcode 0x81 stores each field as (field+1)*8 samples, so the largest value is 524288.
- R4: Opcode 0x83 stores the data word as the read count, and opcode 0x84 stores it as the delay count, taken directly in samples. Any value above 268435456 is clamped to 268435456.
- R5: The last write to a count decides its value, whichever opcode made it. Opcodes 0x83 and 0x84 leave the other count untouched. Any opcode other than 0x00, 0x81, 0x83 and 0x84 changes nothing.
- R6: An `arm` pulse while idle raises `capture_en` at the next clock edge and freezes both counts for the run. An `arm` pulse while a run is in progress is ignored.
- R7: `trigger` acts only while armed and not yet triggered; a trigger while idle leaves `capture_en` and `done` low.
- R8: After the trigger, `capture_en` stays high until the delay count of samples has been accepted. At the edge that accepts the last one, `capture_en` falls and `done` is high for exactly one cycle. With a delay of 0, this happens at the edge after the trigger.
- R9: `read_len` counts the samples accepted while `capture_en` is high, saturating at the frozen read count. It is cleared by arm and holds its value after `done`.
- R10: Opcode 0x00 returns the controller to idle, clears `read_len` and the delay progress, and raises no `done`. It keeps both configured counts.
- R11: A count write during a run changes the configured value at once, but the run in progress keeps the value frozen at its arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 8 | Command opcode |
| cmd_data | input | 32 | Command data word |
| mux_mode | input | 1 | High selects the doubled packed-field scale |
| arm | input | 1 | Start a run |
| trigger | input | 1 | Trigger event |
| smp_valid | input | 1 | Sample stream valid |
| smp_ready | input | 1 | Sample stream ready |
| capture_en | output | 1 | Capture window open |
| done | output | 1 | One-cycle end-of-run pulse |
| read_len | output | 29 | Samples held for readback |
| cfg_read_count | output | 29 | Configured read count |
| cfg_delay_count | output | 29 | Configured delay count |

## Verification
The register path is driven with packed writes at small, zero and all-ones fields in both scale modes. This separates a missing +1, a wrong shift and a swapped half. Full-width writes just below, at and above the ceiling expose a wrong clamp. Interleaved packed and full-width writes show which write wins. The run path is driven with gapped streams in which valid is high without ready, which catches a counter that ignores ready. Pre-trigger fills longer and shorter than the read count test saturation. A zero delay, a mid-run write, a mid-run re-arm and a mid-run reset opcode each separate frozen lengths from live ones.

// File: rtl/caplen_pkg.sv
package caplen_pkg;
  localparam int CMD_W  = 8;
  localparam int DATA_W = 32;

  localparam logic [CMD_W-1:0] OP_RESET  = 8'h00;
  localparam logic [CMD_W-1:0] OP_PACKED = 8'h81;
  localparam logic [CMD_W-1:0] OP_RDLEN  = 8'h83;
  localparam logic [CMD_W-1:0] OP_DLYLEN = 8'h84;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_POST  = 2'd2
  } run_state_t;
endpackage

// File: rtl/caplen_cfg.sv
module caplen_cfg
  import caplen_pkg::*;
#(
  parameter int CNT_W       = 29,
  parameter int MAX_SAMPLES = 268435456,
  parameter int FIELD_W     = 16,
  parameter int BASE_SHIFT  = 2,
  parameter int MUX_SHIFT   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_op,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              mux_mode,
  output logic [CNT_W-1:0]  cfg_read,
  output logic [CNT_W-1:0]  cfg_delay
);
  localparam logic [CNT_W-1:0]  RESET_CNT = CNT_W'(1) << BASE_SHIFT;
  localparam logic [CNT_W-1:0]  MAX_CNT   = CNT_W'(MAX_SAMPLES);
  localparam logic [DATA_W-1:0] MAX_WORD  = DATA_W'(MAX_SAMPLES);

  function automatic logic [CNT_W-1:0] scale_field(input logic [FIELD_W-1:0] f,
                                                   input logic m);
    logic [CNT_W-1:0] units;
    units = {{(CNT_W-FIELD_W){1'b0}}, f} + CNT_W'(1);
    return m ? (units << MUX_SHIFT) : (units << BASE_SHIFT);
  endfunction

  logic [CNT_W-1:0] packed_rd, packed_dly, wide_val;
  logic             wr_packed, wr_rd, wr_dly;

  always_comb begin
    packed_rd  = scale_field(cmd_data[FIELD_W-1:0], mux_mode);
    packed_dly = scale_field(cmd_data[2*FIELD_W-1:FIELD_W], mux_mode);
    wide_val   = (cmd_data > MAX_WORD) ? MAX_CNT : cmd_data[CNT_W-1:0];
    wr_packed  = cmd_valid && (cmd_op == OP_PACKED);
    wr_rd      = cmd_valid && (cmd_op == OP_RDLEN);
    wr_dly     = cmd_valid && (cmd_op == OP_DLYLEN);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_read  <= RESET_CNT;
      cfg_delay <= RESET_CNT;
    end else begin
      if (wr_packed) begin
        cfg_read  <= packed_rd;
        cfg_delay <= packed_dly;
      end
      if (wr_rd)  cfg_read  <= wide_val;
      if (wr_dly) cfg_delay <= wide_val;
    end
  end

  p_no_stray_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_packed || wr_rd || wr_dly) |=> $stable(cfg_read) && $stable(cfg_delay));
  p_ceiling_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_read <= MAX_CNT) && (cfg_delay <= MAX_CNT));
  p_rd_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rd |=> $stable(cfg_delay));
endmodule

// File: rtl/caplen_fill.sv
module caplen_fill #(
  parameter int CNT_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)                      count <= '0;
    else if (clr)                    count <= '0;
    else if (inc && (count < limit)) count <= count + CNT_W'(1);
  end

  p_fill_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> count <= limit);
  p_fill_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(count));
endmodule

// File: rtl/caplen_seq.sv
module caplen_seq
  import caplen_pkg::*;
#(
  parameter int CNT_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_cmd,
  input  logic             arm,
  input  logic             trigger,
  input  logic             smp_acc,
  input  logic [CNT_W-1:0] cfg_read,
  input  logic [CNT_W-1:0] cfg_delay,
  output logic             capture_en,
  output logic             done,
  output logic             fill_clr,
  output logic [CNT_W-1:0] act_read
);
  run_state_t       state;
  logic [CNT_W-1:0] act_delay, post_cnt;
  logic             last_smp;

  always_comb begin
    capture_en = (state != ST_IDLE);
    fill_clr   = rst_cmd || ((state == ST_IDLE) && arm);
    last_smp   = smp_acc && (post_cnt == act_delay - CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      done      <= 1'b0;
      post_cnt  <= '0;
      act_read  <= '0;
      act_delay <= '0;
    end else begin
      done <= 1'b0;
      if (rst_cmd) begin
        state    <= ST_IDLE;
        post_cnt <= '0;
      end else begin
        unique case (state)
          ST_IDLE: if (arm) begin
            state     <= ST_ARMED;
            act_read  <= cfg_read;
            act_delay <= cfg_delay;
            post_cnt  <= '0;
          end
          ST_ARMED: if (trigger) begin
            if (act_delay == '0) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              state <= ST_POST;
            end
          end
          ST_POST: if (last_smp) begin
            state    <= ST_IDLE;
            done     <= 1'b1;
            post_cnt <= '0;
          end else if (smp_acc) begin
            post_cnt <= post_cnt + CNT_W'(1);
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_closes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !capture_en);
  p_rstcmd_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cmd |=> !capture_en && !done);
  p_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_en && !rst_cmd) |=> $stable(act_delay) && $stable(act_read));
  p_post_below_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_POST) |-> post_cnt < act_delay);
endmodule

// File: rtl/capture_len_ctrl.sv
module capture_len_ctrl
  import caplen_pkg::*;
#(
  parameter int MAX_SAMPLES = 268435456,
  parameter int FIELD_W     = 16,
  parameter int CNT_W       = $clog2(MAX_SAMPLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_op,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              mux_mode,
  input  logic              arm,
  input  logic              trigger,
  input  logic              smp_valid,
  input  logic              smp_ready,
  output logic              capture_en,
  output logic              done,
  output logic [CNT_W-1:0]  read_len,
  output logic [CNT_W-1:0]  cfg_read_count,
  output logic [CNT_W-1:0]  cfg_delay_count
);
  logic             rst_cmd, smp_acc, fill_clr;
  logic [CNT_W-1:0] act_read;

  always_comb begin
    rst_cmd = cmd_valid && (cmd_op == OP_RESET);
    smp_acc = smp_valid && smp_ready && capture_en;
  end

  caplen_cfg #(
    .CNT_W(CNT_W), .MAX_SAMPLES(MAX_SAMPLES), .FIELD_W(FIELD_W),
    .BASE_SHIFT(2), .MUX_SHIFT(3)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .mux_mode(mux_mode),
    .cfg_read(cfg_read_count), .cfg_delay(cfg_delay_count)
  );

  caplen_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .rst_cmd(rst_cmd), .arm(arm),
    .trigger(trigger), .smp_acc(smp_acc),
    .cfg_read(cfg_read_count), .cfg_delay(cfg_delay_count),
    .capture_en(capture_en), .done(done), .fill_clr(fill_clr),
    .act_read(act_read)
  );

  caplen_fill #(.CNT_W(CNT_W)) u_fill (
    .clk(clk), .rst_n(rst_n), .clr(fill_clr), .inc(smp_acc),
    .limit(act_read), .count(read_len)
  );

  p_idle_no_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture_en && !rst_cmd && !arm) |=> $stable(read_len));
  p_trig_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture_en && !arm) |=> !capture_en);
endmodule

// File: tb/capture_len_ctrl_test.sv
module capture_len_ctrl_test;
  localparam int CW = 29;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [7:0]    cmd_op = '0;
  logic [31:0]   cmd_data = '0;
  logic          mux_mode = 1'b0;
  logic          arm = 1'b0, trigger = 1'b0;
  logic          smp_valid = 1'b0, smp_ready = 1'b0;
  logic          capture_en, done;
  logic [CW-1:0] read_len, cfg_read_count, cfg_delay_count;

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  capture_len_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .mux_mode(mux_mode), .arm(arm), .trigger(trigger),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .capture_en(capture_en),
    .done(done), .read_len(read_len), .cfg_read_count(cfg_read_count),
    .cfg_delay_count(cfg_delay_count)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] op, input logic [31:0] d);
    @(negedge clk); cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic pulse_arm();
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
  endtask

  task automatic pulse_trig();
    @(negedge clk); trigger = 1'b1;
    @(negedge clk); trigger = 1'b0;
  endtask

  task automatic push(input int n, input logic rdy);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); smp_valid = 1'b1; smp_ready = rdy;
    end
    @(negedge clk); smp_valid = 1'b0; smp_ready = 1'b0;
  endtask

  // single-cycle sample so the next negedge observes its effect
  task automatic push1();
    @(negedge clk); smp_valid = 1'b1; smp_ready = 1'b1;
    @(negedge clk); smp_valid = 1'b0; smp_ready = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 capture_en", capture_en, 0);
    check("R1 done", done, 0);
    check("R1 read_len", read_len, 0);
    check("R1 cfg_read", cfg_read_count, 4);
    check("R1 cfg_delay", cfg_delay_count, 4);
  endtask

  task automatic t_packed();
    mux_mode = 1'b0;
    wr(8'h81, {16'd9, 16'd2});
    check("R2 read low half", cfg_read_count, 12);
    check("R2 delay high half", cfg_delay_count, 40);
    wr(8'h81, 32'hFFFF_FFFF);
    check("R2 max read", cfg_read_count, 262144);
    check("R2 max delay", cfg_delay_count, 262144);
    mux_mode = 1'b1;
    wr(8'h81, {16'd9, 16'd2});
    check("R3 mux read", cfg_read_count, 24);
    check("R3 mux delay", cfg_delay_count, 80);
    wr(8'h81, 32'hFFFF_FFFF);
    check("R3 mux max read", cfg_read_count, 524288);
    check("R3 mux max delay", cfg_delay_count, 524288);
    mux_mode = 1'b0;
  endtask

  task automatic t_wide();
    wr(8'h83, 32'd1000);
    check("R4 wide read", cfg_read_count, 1000);
    check("R5 delay untouched", cfg_delay_count, 524288);
    wr(8'h84, 32'd5);
    check("R4 wide delay", cfg_delay_count, 5);
    check("R5 read untouched", cfg_read_count, 1000);
    wr(8'h83, 32'hFFFF_FFFF);
    check("R4 clamp all ones", cfg_read_count, 268435456);
    wr(8'h84, 32'd268435457);
    check("R4 clamp just above", cfg_delay_count, 268435456);
    wr(8'h83, 32'd268435455);
    check("R4 just below ceiling", cfg_read_count, 268435455);
  endtask

  task automatic t_last_wins();
    wr(8'h83, 32'd777);
    wr(8'h81, {16'd1, 16'd0});
    check("R5 packed after wide read", cfg_read_count, 4);
    check("R5 packed after wide delay", cfg_delay_count, 8);
    wr(8'h84, 32'd33);
    check("R5 wide after packed delay", cfg_delay_count, 33);
    check("R5 wide after packed read", cfg_read_count, 4);
    wr(8'h82, 32'hFFFF_FFFF);
    check("R5 unknown op read", cfg_read_count, 4);
    check("R5 unknown op delay", cfg_delay_count, 33);
  endtask

  task automatic t_run();
    wr(8'h83, 32'd3);
    wr(8'h84, 32'd5);
    pulse_trig();
    check("R7 trigger idle capture_en", capture_en, 0);
    check("R7 trigger idle done", done, 0);
    pulse_arm();
    check("R6 arm opens", capture_en, 1);
    push(10, 1'b1);
    check("R9 saturates at read count", read_len, 3);
    pulse_trig();
    push(4, 1'b1);
    push(3, 1'b0);
    check("R8 open before last", capture_en, 1);
    check("R8 no early done", done, 0);
    push1();
    check("R8 done on last", done, 1);
    check("R8 closes on last", capture_en, 0);
    @(negedge clk);
    check("R8 done one cycle", done, 0);
    check("R9 holds after done", read_len, 3);
  endtask

  task automatic t_midwrite();
    wr(8'h84, 32'd3);
    pulse_arm();
    wr(8'h84, 32'd10);
    check("R11 cfg updates live", cfg_delay_count, 10);
    pulse_arm();
    pulse_trig();
    push(2, 1'b1);
    check("R6 R11 still open", capture_en, 1);
    push1();
    check("R11 frozen delay done", done, 1);
    check("R6 rearm ignored", capture_en, 0);
  endtask

  task automatic t_partial();
    wr(8'h83, 32'd12);
    wr(8'h84, 32'd3);
    pulse_arm();
    check("R9 cleared by arm", read_len, 0);
    push(2, 1'b1);
    pulse_trig();
    push(2, 1'b1);
    push1();
    check("R8 partial done", done, 1);
    check("R9 short fill", read_len, 5);
  endtask

  task automatic t_zero();
    wr(8'h84, 32'd0);
    pulse_arm();
    pulse_trig();
    check("R8 zero delay done", done, 1);
    check("R8 zero delay closes", capture_en, 0);
  endtask

  task automatic t_rstcmd();
    wr(8'h84, 32'd6);
    pulse_arm();
    push(2, 1'b1);
    pulse_trig();
    push(2, 1'b1);
    wr(8'h00, 32'd0);
    check("R10 idle", capture_en, 0);
    check("R10 no done", done, 0);
    check("R10 read_len cleared", read_len, 0);
    check("R10 keeps delay", cfg_delay_count, 6);
    check("R10 keeps read", cfg_read_count, 12);
    push(6, 1'b1);
    check("R10 stays idle", done, 0);
    pulse_arm();
    pulse_trig();
    push(5, 1'b1);
    check("R10 progress cleared", capture_en, 1);
    push1();
    check("R10 fresh run done", done, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_packed();
    t_wide();
    t_last_wins();
    t_run();
    t_midwrite();
    t_partial();
    t_zero();
    t_rstcmd();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule